// File: doc/BRIEF.md
# IR Pulse Run-Length Sampler

This block watches one asynchronous infrared receiver line and turns it into a stream of run-length bytes. The line passes through a two-flop synchronizer and an optional inversion. It is then sampled once every `DIV` clock cycles. With an 8 MHz clock and the default divider of 64, one sample lasts 8 us. Each confirmed level run is reported as one byte. The top bit holds the level: 1 for the active (pulse) level and 0 for a space. The lower seven bits hold the number of samples in the run minus one.

Runs of at most `noise_thr` samples count as glitches and are folded into the run around them. A run longer than 128 samples is split into full bytes carrying a length field of 0x7F. Once a space has lasted more than `idle_thr` samples, the block raises a single packet-end strobe. It then reports nothing until the next pulse is confirmed, so the space that ends a packet is never sent as a byte.

The control state machine has three states. `ST_IDLE` means the line is quiet and no run is open. `ST_MARK` means a pulse run is open. `ST_SPACE` means a space run is open inside a packet. The transitions are as follows:
- *pulse-confirm* takes `ST_IDLE` to `ST_MARK`.
- *space-confirm* takes `ST_MARK` to `ST_SPACE`.
- *space-confirm-idle* takes `ST_MARK` straight to `ST_IDLE` when the confirming space already exceeds the idle threshold.
- *pulse-confirm* takes `ST_SPACE` to `ST_MARK`.
- *idle-trip* takes `ST_SPACE` to `ST_IDLE`.
- *disable* takes any state to `ST_IDLE`.

Top module: `ir_run_sampler`

## Requirements
- R1: While `en` is high, the line is sampled once every `DIV` clock cycles. A level held for exactly N×DIV clock cycles counts as exactly N samples. The output strobes are registered and last one cycle.
- R2: With `invert` high, the raw line is complemented before sampling, so a low raw level reports as a pulse (bit 7 = 1).
- R3: Each byte is {level, length-1}. Bit 7 is 1 for a pulse and 0 for a space. Bits 6:0 hold the run length in samples minus one.
- R4: A run of at most `noise_thr` samples is not reported. Its samples are added to the surrounding run, which continues as one run.
- R5: A new level is confirmed on its (`noise_thr`+1)-th sample. All of its samples, including the confirming ones, count toward its length. With `noise_thr` = 0, a single sample is a run.
- R6: Every time an open run reaches 128 samples, byte {level, 0x7F} is sent and counting starts again. A run that is an exact multiple of 128 sends no further byte when it ends.
- R7: When a space exceeds `idle_thr` samples, `pkt_end` pulses once. No byte is sent for that space, either then or while the line stays quiet.
- R8: After reset or re-enable, the block starts in `ST_IDLE` with all outputs low. A leading space before the first pulse is neither reported nor ends a packet.
- R9: With `en` low, no byte and no packet-end is produced, and the run state is cleared.
- R10: When a space is confirmed already longer than `idle_thr`, the closing pulse byte and `pkt_end` come in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sampler enable; low clears the run state |
| invert | input | 1 | Complement the raw line before sampling |
| ir_in | input | 1 | Asynchronous raw receiver line |
| noise_thr | input | NTHR_W (6) | Longest run, in samples, treated as a glitch |
| idle_thr | input | ITHR_W (8) | Space length, in samples, that must be exceeded to end a packet |
| byte_vld | output | 1 | One-cycle strobe marking a valid run byte |
| byte_data | output | LEN_W+1 (8) | Run byte: level in the top bit, length-1 below |
| pkt_end | output | 1 | One-cycle packet-end strobe |

## Verification
The close of a pulse run and the packet-end can fall in the same cycle. This happens when a confirming space is already past the idle threshold. One table row provokes it with a noise threshold of 3 and an idle threshold of 2, so the fourth space sample both confirms the space and trips idle. The bench counts the cycles in which `byte_vld` and `pkt_end` are high together and expects exactly one, carrying the pulse byte 0x89. A second case lets a space overflow 128 samples shortly before a later idle trip, to show that a space byte and packet-end do not merge and that the suppressed residual never appears.

// File: rtl/irs_pkg.sv
`timescale 1ns/1ps
package irs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } run_state_e;
endpackage

// File: rtl/irs_sync.sv
`timescale 1ns/1ps
module irs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    output logic lvl_o
);
    logic [STAGES-1:0] sh_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[0] <= 1'b0;
                    else        sh_q[0] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b0;
                    else        sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    // R2: polarity applied to the synchronized level
    assign lvl_o = sh_q[STAGES-1] ^ invert_i;
endmodule

// File: rtl/irs_tick.sv
`timescale 1ns/1ps
module irs_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!en_i)         cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = en_i && (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R1
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/irs_run_fsm.sv
`timescale 1ns/1ps
module irs_run_fsm
    import irs_pkg::*;
#(
    parameter int LEN_W  = 7,
    parameter int NTHR_W = 6,
    parameter int ITHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              smp_i,
    input  logic [NTHR_W-1:0] nthr_i,
    input  logic [ITHR_W-1:0] ithr_i,
    output logic              byte_vld_o,
    output logic [LEN_W:0]    byte_data_o,
    output logic              pkt_end_o
);
    localparam int RUN_W = LEN_W + 1;
    localparam int SUM_W = LEN_W + 2;
    localparam int CND_W = NTHR_W + 1;
    localparam int IDL_W = ITHR_W + 2;
    localparam int SEG   = 1 << LEN_W;

    run_state_e       st_q, st_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [CND_W-1:0] cand_q, cand_d, cand_inc;
    logic [IDL_W-1:0] idle_q, idle_d, idle_sum, cand_idl, ithr_x;
    logic [SUM_W-1:0] sum;
    logic             cur, confirm;
    logic             emit, pe;
    logic [LEN_W:0]   emit_data;

    assign cand_inc = cand_q + CND_W'(1);
    assign confirm  = cand_inc > {1'b0, nthr_i};
    assign cand_idl = IDL_W'(cand_inc);
    assign ithr_x   = IDL_W'(ithr_i);
    assign sum      = SUM_W'(run_q) + SUM_W'(cand_q) + SUM_W'(1);
    assign idle_sum = idle_q + IDL_W'(cand_q) + IDL_W'(1);
    assign cur      = (st_q == ST_MARK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            run_q  <= '0;
            cand_q <= '0;
            idle_q <= '0;
        end else begin
            st_q   <= st_d;
            run_q  <= run_d;
            cand_q <= cand_d;
            idle_q <= idle_d;
        end
    end

    // next state and emission decision
    always_comb begin
        st_d      = st_q;
        run_d     = run_q;
        cand_d    = cand_q;
        idle_d    = idle_q;
        emit      = 1'b0;
        emit_data = '0;
        pe        = 1'b0;
        if (!en_i) begin
            st_d   = ST_IDLE;
            run_d  = '0;
            cand_d = '0;
            idle_d = '0;
        end else if (tick_i) begin
            if (smp_i != cur) begin
                if (confirm) begin
                    if (st_q != ST_IDLE && run_q != '0) begin
                        emit      = 1'b1;
                        emit_data = {cur, run_q[LEN_W-1:0] - LEN_W'(1)};
                    end
                    cand_d = '0;
                    if (smp_i) begin
                        st_d   = ST_MARK;
                        run_d  = RUN_W'(cand_inc);
                        idle_d = '0;
                    end else if (cand_idl > ithr_x) begin
                        st_d   = ST_IDLE;
                        run_d  = '0;
                        idle_d = '0;
                        pe     = 1'b1;
                    end else begin
                        st_d   = ST_SPACE;
                        run_d  = RUN_W'(cand_inc);
                        idle_d = cand_idl;
                    end
                end else begin
                    cand_d = cand_inc;
                end
            end else begin
                cand_d = '0;
                if (st_q != ST_IDLE) begin
                    if (sum >= SUM_W'(SEG)) begin
                        emit      = 1'b1;
                        emit_data = {cur, {LEN_W{1'b1}}};
                        run_d     = RUN_W'(sum - SUM_W'(SEG));
                    end else begin
                        run_d = RUN_W'(sum);
                    end
                    if (st_q == ST_SPACE) begin
                        idle_d = idle_sum;
                        if (idle_sum > ithr_x) begin
                            st_d   = ST_IDLE;
                            run_d  = '0;
                            idle_d = '0;
                            pe     = 1'b1;
                            emit   = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_vld_o  <= 1'b0;
            byte_data_o <= '0;
            pkt_end_o   <= 1'b0;
        end else begin
            byte_vld_o  <= emit;
            byte_data_o <= emit ? emit_data : '0;
            pkt_end_o   <= pe;
        end
    end

    // R1
    out_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o || pkt_end_o) |-> $past(tick_i));
    // R7
    pe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end_o |=> !pkt_end_o);
    // R7
    pe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end_o |-> (st_q == ST_IDLE));
    // R9
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!byte_vld_o && !pkt_end_o));
    // R10
    idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && st_q == ST_IDLE) |-> (byte_data_o[LEN_W] && pkt_end_o));
    // R6
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(SEG));
endmodule

// File: rtl/ir_run_sampler.sv
`timescale 1ns/1ps
module ir_run_sampler #(
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 7,
    parameter int NTHR_W      = 6,
    parameter int ITHR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              invert,
    input  logic              ir_in,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic              byte_vld,
    output logic [LEN_W:0]    byte_data,
    output logic              pkt_end
);
    logic lvl;
    logic tick;

    irs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (ir_in),
        .invert_i (invert),
        .lvl_o    (lvl)
    );

    irs_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .tick_o (tick)
    );

    irs_run_fsm #(
        .LEN_W  (LEN_W),
        .NTHR_W (NTHR_W),
        .ITHR_W (ITHR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .tick_i      (tick),
        .smp_i       (lvl),
        .nthr_i      (noise_thr),
        .ithr_i      (idle_thr),
        .byte_vld_o  (byte_vld),
        .byte_data_o (byte_data),
        .pkt_end_o   (pkt_end)
    );
endmodule

// File: tb/tb_ir_run_sampler.sv
`timescale 1ns/1ps
module tb_ir_run_sampler;
    localparam int DIV = 8;

    typedef struct packed {
        logic       inv;
        logic [5:0] nthr;
        logic [7:0] ithr;
        logic [8:0] m;
        logic [8:0] s;
        logic [3:0] nb;
        logic [7:0] first;
        logic [7:0] last;
        logic [1:0] npe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 6'd1, 8'd20, 9'd10,  9'd30, 4'd1, 8'h89, 8'h89, 2'd1},
        '{1'b0, 6'd1, 8'd20, 9'd128, 9'd30, 4'd1, 8'hFF, 8'hFF, 2'd1},
        '{1'b0, 6'd1, 8'd20, 9'd130, 9'd30, 4'd2, 8'hFF, 8'h81, 2'd1},
        '{1'b0, 6'd0, 8'd20, 9'd1,   9'd25, 4'd1, 8'h80, 8'h80, 2'd1},
        '{1'b0, 6'd2, 8'd10, 9'd3,   9'd15, 4'd1, 8'h82, 8'h82, 2'd1},
        '{1'b0, 6'd1, 8'd20, 9'd1,   9'd30, 4'd0, 8'h00, 8'h00, 2'd0},
        '{1'b0, 6'd3, 8'd2,  9'd10,  9'd10, 4'd1, 8'h89, 8'h89, 2'd1},
        '{1'b1, 6'd1, 8'd20, 9'd10,  9'd30, 4'd1, 8'h89, 8'h89, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       invert = 1'b0;
    logic       ir_in = 1'b0;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd20;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       pkt_end;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    bit   rec = 1'b0;
    bit   inv_r = 1'b0;
    logic [7:0] got [0:15];
    int   n_got = 0;
    int   n_pe = 0;
    int   n_same = 0;

    always #5 clk = ~clk;

    ir_run_sampler #(.DIV(DIV)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .invert    (invert),
        .ir_in     (ir_in),
        .noise_thr (noise_thr),
        .idle_thr  (idle_thr),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .pkt_end   (pkt_end)
    );

    always @(negedge clk) begin
        if (rec) begin
            if (byte_vld) begin
                if (n_got < 16) got[n_got] = byte_data;
                n_got++;
            end
            if (pkt_end) n_pe++;
            if (byte_vld && pkt_end) n_same++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_vec(input bit inv, input int nthr, input int ithr);
        en = 1'b0;
        inv_r = inv;
        invert = inv;
        ir_in = inv;
        noise_thr = 6'(nthr);
        idle_thr = 8'(ithr);
        repeat (4) @(posedge clk);
        #1;
        n_got = 0;
        n_pe = 0;
        n_same = 0;
        rec = 1'b1;
        en = 1'b1;
    endtask

    task automatic seg(input bit lvl, input int n);
        ir_in = lvl ^ inv_r;
        repeat (n * DIV) @(posedge clk);
        #1;
    endtask

    task automatic end_vec();
        repeat (6 * DIV) @(posedge clk);
        #1;
        rec = 1'b0;
        en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 reset byte_vld", int'(byte_vld), 0);
        chk("R8 reset pkt_end", int'(pkt_end), 0);
        chk("R8 reset byte_data", int'(byte_data), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // table: R1 R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            begin_vec(VEC[i].inv, int'(VEC[i].nthr), int'(VEC[i].ithr));
            seg(1'b1, int'(VEC[i].m));
            seg(1'b0, int'(VEC[i].s));
            end_vec();
            chk($sformatf("R3/R5 vec%0d byte count", i), n_got, int'(VEC[i].nb));
            if (VEC[i].nb != 0) begin
                chk($sformatf("R3/R6 vec%0d first byte", i), int'(got[0]), int'(VEC[i].first));
                chk($sformatf("R3/R6 vec%0d last byte", i), int'(got[n_got-1]), int'(VEC[i].last));
            end
            chk($sformatf("R7 vec%0d packet ends", i), n_pe, int'(VEC[i].npe));
            if (i == 6) chk("R10 byte and pkt_end same cycle", n_same, 1);
            else        chk($sformatf("R10 vec%0d no coincidence", i), n_same, 0);
        end

        // R4: glitch merged into surrounding pulse (10+1+10 = 21 -> 0x94)
        begin_vec(1'b0, 1, 20);
        seg(1'b1, 10);
        seg(1'b0, 1);
        seg(1'b1, 10);
        seg(1'b0, 30);
        end_vec();
        chk("R4 merged count", n_got, 1);
        chk("R4 merged byte", int'(got[0]), 'h94);
        chk("R4 merged pkt_end", n_pe, 1);

        // R3: in-packet space byte has bit7 = 0
        begin_vec(1'b0, 1, 20);
        seg(1'b1, 5);
        seg(1'b0, 8);
        seg(1'b1, 5);
        seg(1'b0, 30);
        end_vec();
        chk("R3 space count", n_got, 3);
        chk("R3 pulse byte", int'(got[0]), 'h84);
        chk("R3 space byte", int'(got[1]), 'h07);
        chk("R3 second pulse", int'(got[2]), 'h84);
        chk("R7 one pkt_end", n_pe, 1);

        // R6 and R7: space overflow inside packet, residual dropped at idle trip
        begin_vec(1'b0, 1, 200);
        seg(1'b1, 5);
        seg(1'b0, 130);
        seg(1'b1, 5);
        seg(1'b0, 250);
        end_vec();
        chk("R6 long space count", n_got, 5);
        chk("R6 space full byte", int'(got[1]), 'h7F);
        chk("R6 space residual", int'(got[2]), 'h01);
        chk("R7 full space byte before idle", int'(got[4]), 'h7F);
        chk("R7 long space pkt_end", n_pe, 1);

        // R8: leading space after enable is not reported
        begin_vec(1'b0, 1, 20);
        seg(1'b0, 50);
        seg(1'b1, 10);
        seg(1'b0, 30);
        end_vec();
        chk("R8 leading space count", n_got, 1);
        chk("R8 leading space byte", int'(got[0]), 'h89);
        chk("R8 leading space pkt_end", n_pe, 1);

        // R9: disabled sampler stays silent
        begin_vec(1'b0, 1, 20);
        en = 1'b0;
        seg(1'b1, 20);
        seg(1'b0, 30);
        seg(1'b1, 140);
        seg(1'b0, 30);
        repeat (4 * DIV) @(posedge clk);
        #1;
        rec = 1'b0;
        chk("R9 disabled bytes", n_got, 0);
        chk("R9 disabled pkt_end", n_pe, 0);

        finish_run();
    end
endmodule